// File: doc/BRIEF.md
# Beacon Timing Synchronisation and Event Timer Unit

This block keeps a 64-bit free-running microsecond counter for timing synchronisation, plus four 16-bit event timers that mark the points of a beacon cycle. The four timers are the beacon target, the DMA alert, the software alert and the end of the announcement window. A timer fires a one-cycle event pulse when the counter reaches its value. At the same moment it moves itself forward by the beacon period. The beacon target and window-end timers count in time units of 1024 µs. The two alert timers count in eighths of a time unit.

Software programs the block through a simple write port. That port loads either half of the counter, any of the four timers, and a control word. The control word holds the period, a run enable, and a counter-clear toggle. A combinational status output reports whether two spacings are still consistent: the window-end timer against the target, and the DMA alert against the target. The check tolerates the moment when one timer has already moved forward and the other has not, and it also tolerates 16-bit wraparound. A driver can use this output to detect timers that have drifted apart after a counter jump.

Top module: `bcn_tsf_unit`

## Requirements
- R1: After reset the counter reads 0, all four timers read 0, no event pulse is high, the period is 0 and the run enable is clear.
- R2: The counter increases by exactly 1 on each clock where `us_tick` is high and no write happens. Without a tick it holds its value.
- R3: A write to address 0 replaces counter bits [31:0], and a write to address 1 replaces bits [63:32]. The new value appears after that clock edge, in place of any increment, and the other half is kept.
- R4: A write to address 6 with data bit 17 set flips an internal clear flag. When the flag goes from 0 to 1, the counter becomes 0 at that edge. The following such write returns the flag to 0 and does not clear the counter.
- R5: The beacon target timer (address 2, event bit 0, `tmr_vals[15:0]`) and the window-end timer (address 5, event bit 3, `tmr_vals[63:48]`) compare against counter bits [25:10]. On the first cycle of equality each one gives a pulse of exactly one clock, and its value becomes value + period modulo 2^16.
- R6: The DMA alert timer (address 3, event bit 1, `tmr_vals[31:16]`) and the software alert timer (address 4, event bit 2, `tmr_vals[47:32]`) compare against counter bits [22:7], which is eighth-unit resolution. When they fire, they move forward by period × 8 modulo 2^16.
- R7: The control word at address 6 carries the period in bits [15:0] and the run enable in bit 16. While the enable is clear, no event pulse occurs and no timer moves forward.
- R8: If the counter is loaded past a timer's value, that timer does not fire and keeps its value until the 16-bit view comes round to it again.
- R9: `win_ok` is high only when two pairs both pass. The first pair is (target, window-end) with a gap of 1. The second pair is (DMA alert shifted right by 3, target) with a gap of DMA_LEAD. A pair (a, b) with gap g and period p passes if b−a=g, or a−b=p−g, or (a|0x10000)−b=p−g, or (b|0x10000)−a=g.
- R10: A write to addresses 2 to 5 loads the chosen timer directly. That write takes priority over a move forward in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-microsecond count enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0/1 counter halves, 2..5 timers, 6 control) |
| wr_data | input | 32 | Write data |
| tsf_out | output | 64 | Current counter value |
| tmr_vals | output | 64 | Four timers packed, target in the low 16 bits |
| evt_pulse | output | 4 | Event pulses: target, DMA alert, software alert, window end |
| win_ok | output | 1 | Timer spacing consistency status |

## Verification
A stuck or misrouted counter shows up on `tsf_out` one clock after the faulty edge. That same fault then moves or suppresses the events on `evt_pulse` by whole units of 1024 clocks. A timer that moves forward by the wrong step shows up in `tmr_vals` on the cycle of its pulse. It also shows up in `win_ok` as soon as the spacing drifts. The scoreboard pairs each pulse with the expected timer and its new value, so pulses that come out of order, come twice, or are missing are all caught. Separate directed loads cover the cases of jumping past a timer, running disabled, and 16-bit wraparound.

// File: rtl/bcn_tsf_pkg.sv
package bcn_tsf_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_TMR  = 4;
  // timer slots; index equals event bit and packing position
  localparam int IDX_TGT  = 0;
  localparam int IDX_DMA  = 1;
  localparam int IDX_SWA  = 2;
  localparam int IDX_ATIM = 3;
  // write map
  localparam logic [ADDR_W-1:0] ADR_TSF_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TSF_HI   = 3'd1;
  localparam int                ADR_TMR_BASE = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 3'd6;
  // control word fields
  localparam int CTRL_EN_BIT  = 16;
  localparam int CTRL_CLR_BIT = 17;

  function automatic bit is_fine_slot(int idx);
    return (idx == IDX_DMA) || (idx == IDX_SWA);
  endfunction
endpackage

// File: rtl/bcn_tsf_counter.sv
module bcn_tsf_counter #(
  parameter int TSF_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_val,
  output logic [TSF_W-1:0]  tsf
);
  localparam int HI_W = TSF_W - HALF_W;

  // clear beats a load, a load beats the increment
  always_ff @(posedge clk) begin
    if (rst) begin
      tsf <= '0;
    end else if (clr) begin
      tsf <= '0;
    end else if (wr_lo) begin
      tsf[HALF_W-1:0] <= wr_val;
    end else if (wr_hi) begin
      tsf[TSF_W-1:HALF_W] <= HI_W'(wr_val);
    end else if (tick) begin
      tsf <= tsf + TSF_W'(1);
    end
  end
endmodule

// File: rtl/bcn_ctrl_reg.sv
module bcn_ctrl_reg #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [TMR_W-1:0] period_in,
  input  logic             en_in,
  input  logic             clr_in,
  output logic [TMR_W-1:0] period,
  output logic             enable,
  output logic             clr_pulse
);
  logic clr_flag;

  // counter clears only when the internal flag rises
  assign clr_pulse = wr && clr_in && !clr_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      period   <= '0;
      enable   <= 1'b0;
      clr_flag <= 1'b0;
    end else if (wr) begin
      period <= period_in;
      enable <= en_in;
      if (clr_in) clr_flag <= ~clr_flag;
    end
  end
endmodule

// File: rtl/bcn_event_timer.sv
module bcn_event_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] view,
  input  logic [W-1:0] step,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val,
  output logic         evt
);
  logic match, match_q, fire;

  assign match = (view == val);
  // edge-qualified so a zero step cannot repeat the pulse
  assign fire  = en && match && !match_q && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      val     <= '0;
      evt     <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= en && match;
      evt     <= fire;
      if (wr)        val <= wr_val;
      else if (fire) val <= val + step;
    end
  end
endmodule

// File: rtl/bcn_win_check.sv
module bcn_win_check #(
  parameter int W = 16
) (
  input  logic [W-1:0] early,
  input  logic [W-1:0] late,
  input  logic [W-1:0] gap,
  input  logic [W-1:0] period,
  output logic         ok
);
  localparam int XW = W + 3;

  logic signed [XW-1:0] a, b, g, p, a_wr, b_wr;

  assign a    = $signed({3'b000, early});
  assign b    = $signed({3'b000, late});
  assign g    = $signed({3'b000, gap});
  assign p    = $signed({3'b000, period});
  assign a_wr = $signed({3'b001, early});
  assign b_wr = $signed({3'b001, late});

  assign ok = ((b - a) == g) ||
              ((a - b) == (p - g)) ||
              ((a_wr - b) == (p - g)) ||
              ((b_wr - a) == g);
endmodule

// File: rtl/bcn_tsf_unit.sv
module bcn_tsf_unit
  import bcn_tsf_pkg::*;
#(
  parameter int TSF_W      = 64,
  parameter int HALF_W     = 32,
  parameter int TMR_W      = 16,
  parameter int TU_SHIFT   = 10,
  parameter int FINE_SHIFT = 3,
  parameter int DMA_LEAD   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     us_tick,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [HALF_W-1:0]        wr_data,
  output logic [TSF_W-1:0]         tsf_out,
  output logic [NUM_TMR*TMR_W-1:0] tmr_vals,
  output logic [NUM_TMR-1:0]       evt_pulse,
  output logic                     win_ok
);
  localparam int FINE_LSB = TU_SHIFT - FINE_SHIFT;

  logic [TMR_W-1:0] view_tu, view_fine;
  logic [TMR_W-1:0] period_q, step_fine;
  logic             enable_q, clr_pulse;
  logic             wr_lo, wr_hi, wr_ctrl;
  logic [TMR_W-1:0] tmr [NUM_TMR];
  logic             ok_atim, ok_dma;

  assign wr_lo   = wr_en && (wr_addr == ADR_TSF_LO);
  assign wr_hi   = wr_en && (wr_addr == ADR_TSF_HI);
  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);

  assign view_tu   = tsf_out[TU_SHIFT +: TMR_W];
  assign view_fine = tsf_out[FINE_LSB +: TMR_W];
  assign step_fine = period_q << FINE_SHIFT;

  bcn_tsf_counter #(.TSF_W(TSF_W), .HALF_W(HALF_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (us_tick),
    .clr    (clr_pulse),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_val (wr_data),
    .tsf    (tsf_out)
  );

  bcn_ctrl_reg #(.TMR_W(TMR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_ctrl),
    .period_in (wr_data[TMR_W-1:0]),
    .en_in     (wr_data[CTRL_EN_BIT]),
    .clr_in    (wr_data[CTRL_CLR_BIT]),
    .period    (period_q),
    .enable    (enable_q),
    .clr_pulse (clr_pulse)
  );

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    localparam bit                FINE   = is_fine_slot(gi);
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(ADR_TMR_BASE + gi);
    logic tmr_wr;
    assign tmr_wr = wr_en && (wr_addr == MY_ADR);

    bcn_event_timer #(.W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .en     (enable_q),
      .view   (FINE ? view_fine : view_tu),
      .step   (FINE ? step_fine : period_q),
      .wr     (tmr_wr),
      .wr_val (wr_data[TMR_W-1:0]),
      .val    (tmr[gi]),
      .evt    (evt_pulse[gi])
    );
    assign tmr_vals[gi*TMR_W +: TMR_W] = tmr[gi];
  end

  bcn_win_check #(.W(TMR_W)) u_win_atim (
    .early  (tmr[IDX_TGT]),
    .late   (tmr[IDX_ATIM]),
    .gap    (TMR_W'(1)),
    .period (period_q),
    .ok     (ok_atim)
  );

  bcn_win_check #(.W(TMR_W)) u_win_dma (
    .early  (tmr[IDX_DMA] >> FINE_SHIFT),
    .late   (tmr[IDX_TGT]),
    .gap    (TMR_W'(DMA_LEAD)),
    .period (period_q),
    .ok     (ok_dma)
  );

  assign win_ok = ok_atim && ok_dma;
endmodule

// File: rtl/bcn_tsf_unit_chk.sv
module bcn_tsf_unit_chk #(
  parameter int TSF_W = 64,
  parameter int TMR_W = 16,
  parameter int NUM_T = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   us_tick,
  input logic                   wr_en,
  input logic [TSF_W-1:0]       tsf_out,
  input logic [NUM_T*TMR_W-1:0] tmr_vals,
  input logic [NUM_T-1:0]       evt_pulse,
  input logic [TMR_W-1:0]       period,
  input logic                   enable
);
  // R2: one step per tick when nothing is written
  p_tsf_step_r2: assert property (@(posedge clk) disable iff (rst)
    (us_tick && !wr_en) |=> tsf_out == $past(tsf_out) + TSF_W'(1));

  // R2: no tick, no write, no change
  p_tsf_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!us_tick && !wr_en) |=> tsf_out == $past(tsf_out));

  // R5: every pulse lasts one clock
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((evt_pulse & $past(evt_pulse)) == '0));

  // R7: disabled run gives no pulse
  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> evt_pulse == '0);

  // R5: target and window-end move forward by the period
  p_tgt_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[0] |-> tmr_vals[15:0] == TMR_W'($past(tmr_vals[15:0]) + $past(period)));
  p_atim_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[3] |-> tmr_vals[63:48] == TMR_W'($past(tmr_vals[63:48]) + $past(period)));

  // R6: alert timers move forward by eight times the period
  p_dma_rearm_r6: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[1] |-> tmr_vals[31:16] == TMR_W'($past(tmr_vals[31:16]) + TMR_W'({$past(period), 3'b000})));
  p_swa_rearm_r6: assert property (@(posedge clk) disable iff (rst)
    evt_pulse[2] |-> tmr_vals[47:32] == TMR_W'($past(tmr_vals[47:32]) + TMR_W'({$past(period), 3'b000})));
endmodule

bind bcn_tsf_unit bcn_tsf_unit_chk #(.TSF_W(64), .TMR_W(16), .NUM_T(4)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .us_tick   (us_tick),
  .wr_en     (wr_en),
  .tsf_out   (tsf_out),
  .tmr_vals  (tmr_vals),
  .evt_pulse (evt_pulse),
  .period    (period_q),
  .enable    (enable_q)
);

// File: tb/bcn_tsf_unit_bench.sv
module bcn_tsf_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        us_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] tsf_out;
  logic [63:0] tmr_vals;
  logic [3:0]  evt_pulse;
  logic        win_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int idx; logic [15:0] val; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  bcn_tsf_unit u_bcn_tsf_unit (
    .clk(clk), .rst(rst), .us_tick(us_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tsf_out(tsf_out),
    .tmr_vals(tmr_vals), .evt_pulse(evt_pulse), .win_ok(win_ok)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_evt(input int idx, input logic [15:0] val);
    exp_t e;
    e.idx = idx; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 4; i++) begin
        if (evt_pulse[i]) begin
          n_chk++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R5/R6/R7/R8 unexpected pulse actual=%0d expected=none", i);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.idx != i || tmr_vals[i*16 +: 16] !== e.val) begin
              n_fail++;
              $display("FAIL R5/R6 event actual=%0d:%0d expected=%0d:%0d",
                       i, tmr_vals[i*16 +: 16], e.idx, e.val);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tsf", tsf_out, 64'd0);
    check("R1 timers", tmr_vals, 64'd0);
    check("R1 events", {60'd0, evt_pulse}, 64'd0);

    // R2 hold without tick, count with tick
    wait_cyc(5);
    check("R2 hold", tsf_out, 64'd0);
    us_tick = 1'b1;
    wait_cyc(10);
    check("R2 count", tsf_out, 64'd10);
    us_tick = 1'b0;

    // R3 half writes and carry
    reg_wr(3'd1, 32'h0000_0012);
    check("R3 upper write", tsf_out, 64'h12_0000_000A);
    reg_wr(3'd0, 32'hFFFF_FFF0);
    check("R3 lower write", tsf_out, 64'h12_FFFF_FFF0);
    us_tick = 1'b1;
    wait_cyc(16);
    check("R3 carry", tsf_out, 64'h13_0000_0000);
    reg_wr(3'd0, 32'd100);
    check("R3 write beats tick", tsf_out, 64'h13_0000_0064);
    us_tick = 1'b0;

    // R4 clear toggle
    reg_wr(3'd1, 32'd0);
    us_tick = 1'b1;
    reg_wr(3'd6, 32'h0002_0000);
    check("R4 first toggle clears", tsf_out, 64'd0);
    wait_cyc(5);
    reg_wr(3'd6, 32'h0002_0000);
    check("R4 second toggle keeps", tsf_out, 64'd7);
    us_tick = 1'b0;

    // R10 timer loads, R9 consistent spacing
    reg_wr(3'd2, 32'd500);
    reg_wr(3'd3, 32'd3984);
    reg_wr(3'd4, 32'd3960);
    reg_wr(3'd5, 32'd501);
    check("R10 timer load", tmr_vals, {16'd501, 16'd3960, 16'd3984, 16'd500});

    // R5 R6 full beacon cycle
    reg_wr(3'd1, 32'd0);
    reg_wr(3'd0, (32'd494 << 10) - 32'd4);
    reg_wr(3'd6, 32'h0001_0064);
    check("R9 initial spacing", {63'd0, win_ok}, 64'd1);
    expect_evt(2, 16'd4760);
    expect_evt(1, 16'd4784);
    expect_evt(0, 16'd600);
    expect_evt(3, 16'd601);
    us_tick = 1'b1;
    wait_cyc(8400);
    us_tick = 1'b0;
    check("R5/R6 all events seen", exp_q.size(), 64'd0);
    check("R5/R6 rearmed values", tmr_vals, {16'd601, 16'd4760, 16'd4784, 16'd600});
    check("R9 after full cycle", {63'd0, win_ok}, 64'd1);

    // R9 window checks with enable off
    reg_wr(3'd6, 32'd100);
    reg_wr(3'd5, 32'd501);
    check("R9 partial update", {63'd0, win_ok}, 64'd1);
    reg_wr(3'd5, 32'd505);
    check("R9 bad window", {63'd0, win_ok}, 64'd0);
    reg_wr(3'd2, 32'd94);
    reg_wr(3'd3, 32'd736);
    reg_wr(3'd5, 32'd65531);
    check("R9 target wrapped", {63'd0, win_ok}, 64'd1);
    reg_wr(3'd2, 32'd65535);
    reg_wr(3'd3, 32'd776);
    reg_wr(3'd5, 32'd0);
    check("R9 window-end wrapped", {63'd0, win_ok}, 64'd1);

    // R7 disabled: pass the target with no pulse
    reg_wr(3'd2, 32'd700);
    reg_wr(3'd5, 32'd900);
    reg_wr(3'd0, (32'd700 << 10) - 32'd5);
    us_tick = 1'b1;
    wait_cyc(20);
    us_tick = 1'b0;
    check("R7 timer held", tmr_vals[15:0], 64'd700);
    check("R7 no pulse", {60'd0, evt_pulse}, 64'd0);

    // R8 jump past target
    reg_wr(3'd2, 32'd800);
    reg_wr(3'd0, 32'd803 << 10);
    reg_wr(3'd6, 32'h0001_0064);
    us_tick = 1'b1;
    wait_cyc(50);
    us_tick = 1'b0;
    check("R8 skipped timer held", tmr_vals[15:0], 64'd800);

    // R5 modulo wrap of the move forward
    reg_wr(3'd6, 32'd100);
    reg_wr(3'd2, 32'd65530);
    reg_wr(3'd0, (32'd65530 << 10) - 32'd3);
    reg_wr(3'd6, 32'h0001_0064);
    expect_evt(0, 16'd94);
    us_tick = 1'b1;
    wait_cyc(20);
    us_tick = 1'b0;
    check("R5 wrap event seen", exp_q.size(), 64'd0);
    check("R5 wrapped value", tmr_vals[15:0], 64'd94);

    finish_up();
  end
endmodule